// File: doc/BRIEF.md
# DRAM Refresh Scheduler with CAS-before-RAS and RAS-only Modes

This block keeps a bank of asynchronous DRAM alive. It tracks how many refresh cycles the memory is owed and asks the access controller for a slot. When the controller grants a slot, the block drives one complete refresh cycle on the row and column strobes.

An interval timer adds one owed refresh every `INTERVAL_CYC` clock cycles. At 50 MHz, 780 cycles gives about 15.6 us per row, which covers 1024 rows in 16 ms. The owed count saturates at `DEBT_MAX`. This lets the controller put refresh off for a few intervals while a page burst finishes. It raises an urgent flag once no further slack remains.

Each granted slot runs one of two sequences on every strobe group at once:
- **CAS-before-RAS:** all column strobes fall first, then all row strobes. The write enable stays high and the address is ignored.
- **RAS-only:** the column strobes stay high and a 10-bit internal row counter is placed on the address bus.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and directly after synchronous reset: all `ras_n` and `cas_n` bits are 1, `we_n` is 1, `req`, `urgent`, `busy` and `done` are 0, `pending` is 0 and `addr` is 0.
- R2: `pending` increases by one at the `INTERVAL_CYC`-th rising edge after reset release and at every `INTERVAL_CYC`-th edge after that, unless R3 or R9 applies.
- R3: `pending` never exceeds `DEBT_MAX`. A timer expiry while `pending` equals `DEBT_MAX` and no refresh completes leaves it at `DEBT_MAX`. `urgent` is 1 exactly when `pending` equals `DEBT_MAX`.
- R4: `req` is 1 exactly when `pending` is nonzero and `busy` is 0. A refresh starts only on an edge where `grant` is 1, `busy` is 0 and `pending` is nonzero. A `grant` at any other time has no effect.
- R5: A refresh started with `ras_only`=0 shows, from the cycle after the starting edge, these phases in order:
  - `LEAD_CYC` cycles with all `cas_n` bits 0 and all `ras_n` bits 1;
  - `RAS_CYC` cycles with all `ras_n` and all `cas_n` bits 0;
  - `RP_CYC` cycles with all bits 1.
- R6: `we_n` is 1 in every cycle.
- R7: A refresh started with `ras_only`=1 shows `LEAD_CYC` cycles with `ras_n` high, then `RAS_CYC` cycles with all `ras_n` bits 0, then `RP_CYC` cycles with all bits high. `cas_n` stays all ones throughout, and `addr` carries the row counter.
- R8: `addr` holds the row counter. It rises by one at the end of each RAS-only refresh and wraps from 1023 to 0. A CAS-before-RAS refresh leaves it unchanged.
- R9: At the edge that ends the precharge phase, `busy` drops, `done` is 1 for exactly one cycle and `pending` decreases by one. If a timer expiry falls on that same edge, `pending` stays unchanged.
- R10: The mode is taken from `ras_only` on the starting edge. Changing `ras_only` during a refresh does not alter that refresh.
- R11: The `N_BANK` row strobes always carry one common value, and so do the `N_BANK` column strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Controller allows a refresh to start |
| ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| req | output | 1 | Refresh owed and scheduler idle |
| urgent | output | 1 | Owed count at its ceiling; no further postponement |
| pending | output | $clog2(DEBT_MAX+1) | Number of owed refresh cycles |
| busy | output | 1 | Refresh sequence in progress |
| done | output | 1 | One-cycle pulse when a refresh completes |
| ras_n | output | N_BANK | Row strobes, active low |
| cas_n | output | N_BANK | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address for RAS-only refresh |

## Verification
The bench runs a cycle-by-cycle reference model and goes after several corner cases:
- **Saturation of the owed count.** A counter that wrapped past eight would drop to zero and lose refreshes.
- **Timer expiry on the same edge as a completion.** A design that let one of the two win would drift by one refresh per collision.
- **Row counter wrap after 1024 RAS-only cycles.** A wrong wrap would skip rows or step out of range.
- **Mode toggled mid-sequence.** A design that did not latch the mode would mix strobe orders within one cycle.
- **Grant while nothing is owed.** Without the start condition, a spurious refresh would start and the owed count would underflow.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LEAD   = 2'd1,
    SEQ_STROBE = 2'd2,
    SEQ_PRECH  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 780
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= RELOAD;
    else if (cnt_q == '0)   cnt_q <= RELOAD;
    else                    cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);

  generate
    if (INTERVAL_CYC > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int DEBT_MAX = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          owe,
  input  logic                          paid,
  output logic [$clog2(DEBT_MAX+1)-1:0] count
);
  localparam int CW = $clog2(DEBT_MAX + 1);
  localparam logic [CW-1:0] CEIL = CW'(DEBT_MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (owe && !paid) begin
      if (cnt_q != CEIL) cnt_q <= cnt_q + 1'b1;
    end else if (paid && !owe) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;

  // R3
  debt_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CEIL);
  // R3
  debt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CEIL && owe && !paid) |=> cnt_q == CEIL);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    paid |-> cnt_q != '0);
endmodule

// File: rtl/refresh_strobe_seq.sv
module refresh_strobe_seq
  import refresh_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int N_BANK   = 4,
  parameter int LEAD_CYC = 1,
  parameter int RAS_CYC  = 4,
  parameter int RP_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              ras_only,
  input  logic              have_debt,
  output logic              finish,
  output logic              busy,
  output logic              done,
  output logic [N_BANK-1:0] ras_n,
  output logic [N_BANK-1:0] cas_n,
  output logic [ROW_W-1:0]  row
);
  localparam int PH_MAX = (LEAD_CYC > RAS_CYC) ?
                          ((LEAD_CYC > RP_CYC) ? LEAD_CYC : RP_CYC) :
                          ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
  localparam int PW = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

  seq_state_t       state_q, state_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic             ro_q, ro_d;
  logic             start;
  logic [N_BANK-1:0] ras_q, cas_q;
  logic [ROW_W-1:0] row_q;
  logic             busy_q, done_q;

  assign start = (state_q == SEQ_IDLE) && grant && have_debt;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q - 1'b1;
    ro_d    = ro_q;
    finish  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        ph_d = ph_q;
        if (start) begin
          state_d = SEQ_LEAD;
          ph_d    = PW'(LEAD_CYC - 1);
          ro_d    = ras_only;
        end
      end
      SEQ_LEAD: if (ph_q == '0) begin
        state_d = SEQ_STROBE;
        ph_d    = PW'(RAS_CYC - 1);
      end
      SEQ_STROBE: if (ph_q == '0) begin
        state_d = SEQ_PRECH;
        ph_d    = PW'(RP_CYC - 1);
      end
      SEQ_PRECH: if (ph_q == '0) begin
        state_d = SEQ_IDLE;
        ph_d    = '0;
        finish  = 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      ph_q    <= '0;
      ro_q    <= 1'b0;
      ras_q   <= '1;
      cas_q   <= '1;
      row_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      ro_q    <= ro_d;
      ras_q   <= (state_d == SEQ_STROBE) ? '0 : '1;
      cas_q   <= (!ro_d && (state_d == SEQ_LEAD || state_d == SEQ_STROBE)) ? '0 : '1;
      busy_q  <= (state_d != SEQ_IDLE);
      done_q  <= finish;
      if (finish && ro_q) row_q <= row_q + 1'b1;
    end
  end

  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign row   = row_q;
  assign busy  = busy_q;
  assign done  = done_q;

  // R5
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_q[0]) && !ro_q) |-> $past(cas_q[0]) == 1'b0);
  // R7
  ras_only_cas_high_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ro_q) |-> cas_q == '1);
  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(ro_q)) |-> row_q == ROW_W'($past(row_q) + 1'b1));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL_CYC = 780,
  parameter int DEBT_MAX     = 8,
  parameter int ROW_W        = 10,
  parameter int N_BANK       = 4,
  parameter int LEAD_CYC     = 1,
  parameter int RAS_CYC      = 4,
  parameter int RP_CYC       = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          grant,
  input  logic                          ras_only,
  output logic                          req,
  output logic                          urgent,
  output logic [$clog2(DEBT_MAX+1)-1:0] pending,
  output logic                          busy,
  output logic                          done,
  output logic [N_BANK-1:0]             ras_n,
  output logic [N_BANK-1:0]             cas_n,
  output logic                          we_n,
  output logic [ROW_W-1:0]              addr
);
  localparam int CW = $clog2(DEBT_MAX + 1);

  logic          tick;
  logic          finish;
  logic [CW-1:0] debt;

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst(rst), .tick(tick)
  );

  refresh_debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst(rst), .owe(tick), .paid(finish), .count(debt)
  );

  refresh_strobe_seq #(
    .ROW_W(ROW_W), .N_BANK(N_BANK),
    .LEAD_CYC(LEAD_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .grant(grant), .ras_only(ras_only),
    .have_debt(debt != '0), .finish(finish), .busy(busy), .done(done),
    .ras_n(ras_n), .cas_n(cas_n), .row(addr)
  );

  assign pending = debt;
  assign req     = (debt != '0) && !busy;
  assign urgent  = (debt == CW'(DEBT_MAX));
  assign we_n    = 1'b1;

  // R4
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(grant) && $past(debt) != '0));
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int INTERVAL = 10;
  localparam int DMAX     = 8;
  localparam int ROWW     = 10;
  localparam int NB       = 4;
  localparam int LEAD     = 1;
  localparam int RASC     = 4;
  localparam int RPC      = 3;
  localparam int LEN      = LEAD + RASC + RPC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0;
  logic ras_only = 1'b0;
  logic req, urgent, busy, done, we_n;
  logic [3:0] pending;
  logic [NB-1:0] ras_n, cas_n;
  logic [ROWW-1:0] addr;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .INTERVAL_CYC(INTERVAL), .DEBT_MAX(DMAX), .ROW_W(ROWW), .N_BANK(NB),
    .LEAD_CYC(LEAD), .RAS_CYC(RASC), .RP_CYC(RPC)
  ) uut (
    .clk(clk), .rst(rst), .grant(grant), .ras_only(ras_only),
    .req(req), .urgent(urgent), .pending(pending), .busy(busy), .done(done),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  int m_cyc, m_pend, m_left, m_row;
  bit m_busy, m_ro, m_done;
  int n_coinc = 0;
  int n_wrap = 0;
  bit tk, fin, st;

  always @(posedge clk) begin
    if (rst) begin
      m_cyc = 0; m_pend = 0; m_left = 0; m_row = 0;
      m_busy = 0; m_ro = 0; m_done = 0;
    end else begin
      m_cyc = m_cyc + 1;
      tk  = (m_cyc % INTERVAL) == 0;
      fin = m_busy && (m_left == 1);
      st  = !m_busy && (m_pend != 0) && grant;
      if (tk && fin) n_coinc++;
      if (tk && !fin)      m_pend = (m_pend < DMAX) ? m_pend + 1 : DMAX;
      else if (fin && !tk) m_pend = m_pend - 1;
      m_done = fin;
      if (fin) begin
        m_busy = 0;
        if (m_ro) begin
          if (m_row == (1 << ROWW) - 1) n_wrap++;
          m_row = (m_row + 1) % (1 << ROWW);
        end
      end else if (m_busy) begin
        m_left = m_left - 1;
      end else if (st) begin
        m_busy = 1; m_left = LEN; m_ro = ras_only;
      end
    end
  end

  int pos;
  bit e_ras_low, e_cas_low;
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      pos = LEN - m_left;
      e_ras_low = m_busy && pos >= LEAD && pos < LEAD + RASC;
      e_cas_low = m_busy && !m_ro && pos < LEAD + RASC;
      // R5 / R7 / R10 / R11: full strobe vectors against the model
      chk(ras_n == (e_ras_low ? '0 : '1), "R5/R7/R10/R11 ras_n", ras_n, e_ras_low ? 0 : 15);
      chk(cas_n == (e_cas_low ? '0 : '1), "R5/R7/R10/R11 cas_n", cas_n, e_cas_low ? 0 : 15);
      // R6
      chk(we_n == 1'b1, "R6 we_n", we_n, 1);
      // R8
      chk(addr == m_row, "R8 addr", addr, m_row);
      // R2 / R3 / R9
      chk(pending == m_pend, "R2/R3/R9 pending", pending, m_pend);
      // R3
      chk(urgent == (m_pend == DMAX), "R3 urgent", urgent, m_pend == DMAX);
      // R4
      chk(req == (m_pend != 0 && !m_busy), "R4 req", req, m_pend != 0 && !m_busy);
      // R9
      chk(busy == m_busy, "R9 busy", busy, m_busy);
      chk(done == m_done, "R9 done", done, m_done);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    cycles(4);
    // R1: outputs under reset
    chk(ras_n == '1 && cas_n == '1, "R1 strobes", {ras_n, cas_n}, 255);
    chk(we_n == 1'b1, "R1 we_n", we_n, 1);
    chk(!req && !urgent && !busy && !done, "R1 flags", {req, urgent, busy, done}, 0);
    chk(pending == 0 && addr == 0, "R1 counts", pending + addr, 0);
    rst = 1'b0;
    chk_on = 1'b1;
    // R1: state right after release
    chk(pending == 0 && addr == 0 && ras_n == '1, "R1 after release", pending, 0);
    // R4: grant with nothing owed
    grant = 1'b1;
    cycles(5);
    grant = 1'b0;
    // R2: let three intervals accumulate
    cycles(30);
    chk(pending == 3, "R2 three intervals", pending, 3);
    // R5: CAS-before-RAS drain
    ras_only = 1'b0;
    grant = 1'b1;
    cycles(40);
    grant = 1'b0;
    // R3: postpone past the ceiling
    cycles(120);
    chk(pending == DMAX && urgent, "R3 saturated", pending, DMAX);
    // R10: toggle mode during sequences
    grant = 1'b1;
    for (int i = 0; i < 30; i++) begin
      ras_only = ~ras_only;
      cycles(3);
    end
    // R7 / R8: long RAS-only run through the row wrap
    ras_only = 1'b1;
    cycles(10600);
    chk(n_wrap > 0, "R8 row wrap seen", n_wrap, 1);
    // R8: CBR leaves the row alone
    ras_only = 1'b0;
    cycles(100);
    grant = 1'b0;
    cycles(20);
    // R9: expiry coinciding with completion was exercised
    chk(n_coinc > 0, "R9 coincidence seen", n_coinc, 1);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end
endmodule